// File: doc/BRIEF.md
# Write-Once Watchdog Timer

This block is a watchdog for a processor subsystem. Software programs an 8-bit mode register a single time after reset. That write chooses what an overflow does: nothing (the watchdog stops), a one-cycle non-maskable interrupt pulse, or a reset request. The same write chooses the timeout period.

While the watchdog runs, software keeps it from expiring by writing a fixed key byte to a separate restart register. Any breach of protocol forces an immediate overflow event. A breach is a repeated mode write or a restart write that carries the wrong key. Coming out of reset, the mode register already selects reset mode with the longest period, so a hung boot is caught even before software runs.

Both registers sit on a plain single-cycle register bus with one address bit. Reads have no side effects. Event routing follows the mode that is active when the event occurs. The reset request is sticky until the block's own reset is applied.

Top module: `sentry_wdt`

## Requirements
- R1: After reset the mode register reads 0x67 (reset mode, select field 7), both outputs are low, and with no software action `wdt_rst_req` rises 2^(BASE_EXP+7) clock edges after reset is released.
- R2: Mode register bits 6:5 set the mode: 00 stops the count, 01 sends overflows to `wdt_nmi`, and 10 or 11 sends overflows to `wdt_rst_req`. Bit 7 always reads 0.
- R3: Mode register bits 4:0 (the select field S) set the timeout to 2^(BASE_EXP+min(S,7)) clock edges, counted from the edge that last cleared the counter.
- R4: The first mode write (address 0) after reset is stored, reads back with bit 7 cleared, and clears the counter.
- R5: Every later mode write leaves the register unchanged and forces an overflow event on that same clock edge.
- R6: A write of 0xAC to the restart register (address 1) clears the counter and raises no event.
- R7: A write of any other byte to the restart register forces an overflow event on that same clock edge.
- R8: In interrupt mode each overflow, whether natural or forced, gives a one-cycle `wdt_nmi` pulse and restarts the count from zero.
- R9: In reset mode, and for forced events while stopped, `wdt_rst_req` rises and holds high until `rst_n` is asserted. The counter halts while it is high.
- R10: A read of address 1 returns 0x9A. Reads of either address change neither the count nor the outputs.
- R11: Writing 0x1F as the first mode write stops the counter, so no natural overflow follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | 0 = mode register, 1 = restart register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| wdt_nmi | output | 1 | One-cycle non-maskable interrupt pulse |
| wdt_rst_req | output | 1 | Sticky reset request |

## Verification
Internal state in this block can go wrong in three places: the counter, the write-once flag, or the stored mode. Each shows up at the pins as an overflow at the wrong cycle or on the wrong pin. A miscounted period, or a restart that fails to clear, moves the pulse by at least one cycle relative to the last clearing edge. A lost write-once flag shows up at once: the repeated mode write produces no event and the readback changes. Because every expected event carries an exact cycle number, each of these faults surfaces at the first overflow after the faulty cycle.

// File: rtl/sentry_wdt_pkg.sv
package sentry_wdt_pkg;

  localparam int REG_W    = 8;
  localparam int SEL_W    = 5;
  localparam int MODE_LSB = 5;

  typedef enum logic [1:0] {
    MD_STOP  = 2'd0,
    MD_NMI   = 2'd1,
    MD_RESET = 2'd2
  } wdt_mode_e;

  function automatic wdt_mode_e decode_mode(input logic [1:0] f);
    if (f == 2'b00)      return MD_STOP;
    else if (f == 2'b01) return MD_NMI;
    else                 return MD_RESET;
  endfunction

endpackage

// File: rtl/sentry_wdt_regif.sv
module sentry_wdt_regif
  import sentry_wdt_pkg::*;
#(
  parameter logic [REG_W-1:0] KEY_VAL  = 8'hAC,
  parameter logic [REG_W-1:0] READ_VAL = 8'h9A
) (
  input  logic             bus_sel,
  input  logic             bus_we,
  input  logic             bus_addr,
  input  logic [REG_W-1:0] bus_wdata,
  input  logic [REG_W-1:0] mode_q,
  output logic             mode_wr,
  output logic             key_ok,
  output logic             key_bad,
  output logic [REG_W-1:0] rdata
);

  logic wr_cyc;
  logic key_match;

  assign wr_cyc    = bus_sel && bus_we;
  assign key_match = (bus_wdata == KEY_VAL);

  always_comb begin
    mode_wr = 1'b0;
    key_ok  = 1'b0;
    key_bad = 1'b0;
    if (wr_cyc) begin
      if (!bus_addr) mode_wr = 1'b1;
      else if (key_match) key_ok = 1'b1;
      else key_bad = 1'b1;
    end
  end

  assign rdata = bus_addr ? READ_VAL : mode_q;

endmodule

// File: rtl/sentry_wdt_modereg.sv
module sentry_wdt_modereg
  import sentry_wdt_pkg::*;
#(
  parameter logic [REG_W-1:0] RST_VAL = 8'h67
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-2:0] wdata,
  output logic [REG_W-1:0] reg_q,
  output logic             accept,
  output logic             violate,
  output wdt_mode_e        mode,
  output logic [SEL_W-1:0] sel
);

  logic written_q;

  assign accept  = wr_en && !written_q;
  assign violate = wr_en && written_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_q     <= {1'b0, RST_VAL[REG_W-2:0]};
      written_q <= 1'b0;
    end else if (accept) begin
      reg_q     <= {1'b0, wdata};
      written_q <= 1'b1;
    end
  end

  assign mode = decode_mode(reg_q[MODE_LSB+1:MODE_LSB]);
  assign sel  = reg_q[SEL_W-1:0];

  // R5
  mode_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    violate |=> $stable(reg_q));

  // R4
  mode_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (reg_q == {1'b0, $past(wdata)}));

endmodule

// File: rtl/sentry_wdt_counter.sv
module sentry_wdt_counter
  import sentry_wdt_pkg::*;
#(
  parameter int BASE_EXP = 10,
  parameter int NUM_SEL  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clear,
  input  logic [SEL_W-1:0] sel,
  output logic             expire
);

  localparam int CNT_W  = BASE_EXP + NUM_SEL - 1;
  localparam int EFF_W  = (NUM_SEL > 1) ? $clog2(NUM_SEL) : 1;
  localparam int TOP_IX = NUM_SEL - 1;

  logic [CNT_W-1:0] lim_tbl [NUM_SEL];
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim_sel;
  logic [EFF_W-1:0] eff;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_SEL; gi++) begin : g_lim
      assign lim_tbl[gi] = CNT_W'((64'd1 << (BASE_EXP + gi)) - 64'd1);
    end
  endgenerate

  always_comb begin
    if (int'(sel) > TOP_IX) eff = EFF_W'(TOP_IX);
    else                    eff = EFF_W'(sel);
  end

  assign lim_sel = lim_tbl[eff];
  assign expire  = run && (cnt_q == lim_sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (clear)    cnt_q <= '0;
    else if (expire)   cnt_q <= '0;
    else if (run)      cnt_q <= cnt_q + 1'b1;
  end

  // R6
  cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt_q == '0));

  // R11
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clear) |=> $stable(cnt_q));

  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= lim_sel);

endmodule

// File: rtl/sentry_wdt_event.sv
module sentry_wdt_event
  import sentry_wdt_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  wdt_mode_e mode,
  input  logic      expire,
  input  logic      force_evt,
  output logic      nmi,
  output logic      rst_req
);

  logic evt;
  logic nmi_q;
  logic rst_q;

  assign evt = expire || force_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_q <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      nmi_q <= evt && (mode == MD_NMI);
      if (evt && (mode != MD_NMI)) rst_q <= 1'b1;
    end
  end

  assign nmi     = nmi_q;
  assign rst_req = rst_q;

  // R8
  nmi_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_q |=> (!nmi_q || $past(force_evt)));

  // R9
  rst_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_q |=> rst_q);

  // R2
  route_nmi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (force_evt && mode == MD_NMI) |=> nmi_q);

  // R2
  route_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (force_evt && mode != MD_NMI) |=> rst_q);

endmodule

// File: rtl/sentry_wdt.sv
module sentry_wdt
  import sentry_wdt_pkg::*;
#(
  parameter int               BASE_EXP = 10,
  parameter int               NUM_SEL  = 8,
  parameter logic [REG_W-1:0] RST_VAL  = 8'h67,
  parameter logic [REG_W-1:0] KEY_VAL  = 8'hAC,
  parameter logic [REG_W-1:0] READ_VAL = 8'h9A
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_we,
  input  logic             bus_addr,
  input  logic [REG_W-1:0] bus_wdata,
  output logic [REG_W-1:0] bus_rdata,
  output logic             wdt_nmi,
  output logic             wdt_rst_req
);

  logic [REG_W-1:0] mode_q;
  logic             mode_wr, key_ok, key_bad;
  logic             accept, mode_bad;
  logic             expire, force_evt, run, clear;
  wdt_mode_e        mode;
  logic [SEL_W-1:0] sel;

  sentry_wdt_regif #(.KEY_VAL(KEY_VAL), .READ_VAL(READ_VAL)) u_regif (
    .bus_sel  (bus_sel),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .mode_q   (mode_q),
    .mode_wr  (mode_wr),
    .key_ok   (key_ok),
    .key_bad  (key_bad),
    .rdata    (bus_rdata)
  );

  sentry_wdt_modereg #(.RST_VAL(RST_VAL)) u_mode (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (mode_wr),
    .wdata  (bus_wdata[REG_W-2:0]),
    .reg_q  (mode_q),
    .accept (accept),
    .violate(mode_bad),
    .mode   (mode),
    .sel    (sel)
  );

  assign force_evt = mode_bad || key_bad;
  assign run       = (mode != MD_STOP) && !wdt_rst_req;
  assign clear     = key_ok || accept || force_evt;

  sentry_wdt_counter #(.BASE_EXP(BASE_EXP), .NUM_SEL(NUM_SEL)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .clear (clear),
    .sel   (sel),
    .expire(expire)
  );

  sentry_wdt_event u_evt (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode),
    .expire   (expire),
    .force_evt(force_evt),
    .nmi      (wdt_nmi),
    .rst_req  (wdt_rst_req)
  );

  // R10
  read_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_we && !wdt_nmi && !wdt_rst_req && !expire) |=> (!wdt_nmi && !wdt_rst_req));

  // R7
  bad_key_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && bus_addr && bus_wdata != KEY_VAL) |=> (wdt_nmi || wdt_rst_req));

endmodule

// File: tb/tb_sentry_wdt.sv
module tb_sentry_wdt;

  localparam int BEXP = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0;
  logic       bus_we = 1'b0;
  logic       bus_addr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       wdt_nmi;
  logic       wdt_rst_req;

  sentry_wdt #(.BASE_EXP(BEXP)) dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wdt_nmi(wdt_nmi), .wdt_rst_req(wdt_rst_req)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct { bit is_rst; int at; string req; } exp_t;
  exp_t q[$];

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit rst_prev = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d (0x%0h) expected %0d (0x%0h)",
               req, what, act, act, expv, expv);
    end
  endtask

  task automatic observe(input bit is_rst);
    if (q.size() == 0) begin
      chk(0, "R8", is_rst ? "unexpected reset request" : "unexpected nmi", cyc, -1);
    end else begin
      exp_t e = q.pop_front();
      chk(e.is_rst == is_rst && e.at == cyc, e.req,
          is_rst ? "reset request cycle" : "nmi cycle", cyc, e.at);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (!rst_n) rst_prev = 0;
    else begin
      if (wdt_nmi) observe(0);
      if (wdt_rst_req && !rst_prev) observe(1);
      rst_prev = wdt_rst_req;
    end
  end

  task automatic push(input bit is_rst, input int at, input string req);
    exp_t e;
    e.is_rst = is_rst; e.at = at; e.req = req;
    q.push_back(e);
  endtask

  task automatic do_reset(output int c0);
    @(negedge clk);
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk(q.size() == 0, "R8", "pending events at reset", q.size(), 0);
    q.delete();
    chk(!wdt_nmi && !wdt_rst_req, "R9", "outputs during reset", {wdt_nmi, wdt_rst_req}, 0);
    rst_n = 1;
    c0 = cyc;
  endtask

  task automatic bus_write(input bit a, input logic [7:0] d, output int c);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #1;
    c = cyc;
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic bus_read(input bit a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk);
    #1 bus_sel = 0;
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(posedge clk);
    #2;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int c0, e, e3, e4, e5, e6;
    logic [7:0] rd;

    // Reset state and boot timeout in reset mode
    do_reset(c0);
    push(1, c0 + (1 << (BEXP + 7)), "R1");
    bus_read(0, rd);
    chk(rd == 8'h67, "R1", "mode reset value", rd, 8'h67);
    bus_read(1, rd);
    chk(rd == 8'h9A, "R10", "restart readback", rd, 8'h9A);
    chk(!wdt_nmi && !wdt_rst_req, "R1", "outputs after reset", {wdt_nmi, wdt_rst_req}, 0);
    wait_until(c0 + (1 << (BEXP + 7)) + 5);
    chk(wdt_rst_req, "R9", "reset request held", wdt_rst_req, 1);
    repeat (20) @(posedge clk);
    #2 chk(wdt_rst_req, "R9", "reset request still held", wdt_rst_req, 1);

    // Interrupt mode, select 2
    do_reset(c0);
    bus_write(0, 8'h22, e);
    bus_write(1, 8'hAC, e);
    push(0, e + 32, "R3"); push(0, e + 64, "R8");
    repeat (5) begin bus_read(1, rd); bus_read(0, rd); end
    wait_until(e + 66);
    bus_read(0, rd);
    chk(rd == 8'h22, "R4", "mode readback", rd, 8'h22);
    bus_write(1, 8'hAC, e3);
    repeat (20) @(posedge clk);
    bus_write(1, 8'hAC, e4);
    push(0, e4 + 32, "R6");
    wait_until(e4 + 34);
    bus_write(0, 8'h40, e5);
    push(0, e5, "R5"); push(0, e5 + 32, "R8");
    wait_until(e5 + 34);
    bus_read(0, rd);
    chk(rd == 8'h22, "R5", "mode after second write", rd, 8'h22);
    bus_write(1, 8'h55, e6);
    push(0, e6, "R7");
    repeat (10) @(posedge clk);

    // Shortest period, select 0
    do_reset(c0);
    bus_write(0, 8'h20, e);
    bus_write(1, 8'hAC, e);
    push(0, e + 8, "R3"); push(0, e + 16, "R3"); push(0, e + 24, "R3");
    wait_until(e + 26);

    // Saturating select field
    do_reset(c0);
    bus_write(0, 8'hBF, e);
    bus_read(0, rd);
    chk(rd == 8'h3F, "R2", "bit7 reads zero", rd, 8'h3F);
    bus_write(1, 8'hAC, e);
    push(0, e + (1 << (BEXP + 7)), "R3");
    wait_until(e + (1 << (BEXP + 7)) + 2);

    // Reset mode via encoding 10, select 5
    do_reset(c0);
    bus_write(0, 8'h45, e);
    bus_write(1, 8'hAC, e);
    push(1, e + (1 << (BEXP + 5)), "R2");
    wait_until(e + (1 << (BEXP + 5)) + 30);
    chk(wdt_rst_req && !wdt_nmi, "R9", "reset mode event pin", {wdt_nmi, wdt_rst_req}, 1);
    do_reset(c0);
    chk(!wdt_rst_req, "R9", "reset clears request", wdt_rst_req, 0);

    // Stop mode
    bus_write(0, 8'h1F, e);
    bus_read(0, rd);
    chk(rd == 8'h1F, "R11", "stop readback", rd, 8'h1F);
    wait_until(e + 1500);
    chk(!wdt_nmi && !wdt_rst_req, "R11", "no event while stopped", {wdt_nmi, wdt_rst_req}, 0);
    bus_write(1, 8'hAC, e);
    repeat (10) @(posedge clk);
    #2 chk(!wdt_rst_req, "R6", "good key raises nothing", wdt_rst_req, 0);
    bus_write(1, 8'h00, e);
    push(1, e, "R7");
    repeat (5) @(posedge clk);
    #2 chk(wdt_rst_req, "R9", "forced event while stopped", wdt_rst_req, 1);

    do_reset(c0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule